// File: doc/BRIEF.md
# PHY Calibration Write Sequencer

This block applies a short, fixed calibration to a high-speed serial PHY. A one-cycle start pulse launches three writes into the PHY's internal control-register space, always in the same order:

1. The loss-of-signal detector setting.
2. The transmit boost level.
3. The receiver-detect measurement time.

The value of the third write depends on the reference-clock frequency. A reference-clock select code gives that frequency, and the block samples it on the cycle the start is accepted.

Each write goes to a separate register-port master through a level request. The master answers with a one-cycle done or error strobe. The handshake on the PHY side is the master's concern.

When the sequence ends, the block gives a one-cycle done pulse. It also sets an error flag and a failing-step index, and both stay as they are until the next start is accepted. An error on the first or second write ends the sequence at once. An error on the third write is flagged, but the sequence still finishes normally.

Top module: `phy_cal_seq`

## Requirements
- R1: The first write has address 0x0015 and data 0xA409. The data holds a loss-of-signal bias of 5 in bits 15:13, the override enable in bit 10 and a loss-of-signal level of 9 in bits 4:0.
- R2: The second write has address 0x0012 and data 0xA000, which is a boost level of 5 in bits 15:13.
- R3: The third write has address 0x1010. Its data holds a measurement time in bits 4 and up, giving these data values by `ref_sel_i` code:
  - code 0 (19.2 MHz): 0x0040
  - code 1 (20 MHz): 0x0040
  - code 2 (24 MHz): 0x0080
  - code 3 (50 MHz): 0x0200
- R4: Any `ref_sel_i` code from 4 to 7 gives the 24 MHz data 0x0080. The code is sampled on the cycle the start is accepted, and later changes have no effect on the run.
- R5: The writes are issued strictly in the order first, second, third. `wr_req_o` rises the cycle after start acceptance and stays high, with address and data stable, until `wr_done_i` or `wr_err_i`. It then drops for exactly one cycle before the next write.
- R6: An error response to the first or second write ends the sequence. No further write is issued, and the cycle after the response `done_o` pulses with `err_o`=1 and `fail_step_o` equal to the step number (1 or 2).
- R7: An error response to the third write sets `err_o`=1 and `fail_step_o`=3. Completion still follows in the next cycle.
- R8: `done_o` is high for exactly one cycle per sequence. `err_o` and `fail_step_o` (0 when no error) hold their values until the next accepted start, which clears them.
- R9: A start pulse while `busy_o` is high is ignored. Responses from the master while no request is pending are also ignored.
- R10: During and after synchronous active-low reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| ref_sel_i | input | 3 | Reference-clock select code |
| wr_req_o | output | 1 | Write request to the register-port master |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 16 | Write data |
| wr_done_i | input | 1 | Master: write finished without error |
| wr_err_i | input | 1 | Master: write failed |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | A write failed in the last sequence |
| fail_step_o | output | 2 | Failing step number, 0 when none |

## Verification
A wrong step counter shows up on the first response after it goes wrong. The next request then carries the wrong address and data, or the sequence ends one write early or late, and both are visible at the ports within a cycle.

A wrong abort decision changes the number of requests seen before `done_o`. A status register that loses or keeps its value wrongly shows on `err_o` or `fail_step_o` in the cycle after the event.

The reference model is compared against the ports on every clock, so any of these faults is caught in the cycle it first becomes visible.

// File: rtl/phy_cal_pkg.sv
// Package: shared types and constants of the PHY calibration sequencer.
// Assumes: three writes, steps numbered 1..3 on the status port.
package phy_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_t;

    localparam int unsigned NUM_STEPS = 3;

    // Reference-clock select codes
    localparam logic [2:0] REF_19M2 = 3'd0;
    localparam logic [2:0] REF_20M  = 3'd1;
    localparam logic [2:0] REF_24M  = 3'd2;
    localparam logic [2:0] REF_50M  = 3'd3;

endpackage

// File: rtl/phy_cal_table.sv
// Module: phy_cal_table
// Gives the address and data of a calibration step. The third step's data is
// picked from the captured reference-clock code.
// Assumes: step_idx is 0..2 while a request is active; other values give 0.
module phy_cal_table
    import phy_cal_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SEL_W  = 3
) (
    input  logic [1:0]        step_idx,
    input  logic [SEL_W-1:0]  ref_sel,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned FLD_LSB   = 13;
    localparam int unsigned OVR_BIT   = 10;
    localparam int unsigned MEAS_LSB  = 4;
    localparam logic [DATA_W-1:0] LOS_WORD   =
        DATA_W'((5 << FLD_LSB) | (1 << OVR_BIT) | 9);
    localparam logic [DATA_W-1:0] BOOST_WORD = DATA_W'(5 << FLD_LSB);
    localparam logic [ADDR_W-1:0] A_LOS   = ADDR_W'('h0015);
    localparam logic [ADDR_W-1:0] A_BOOST = ADDR_W'('h0012);
    localparam logic [ADDR_W-1:0] A_RXDET = ADDR_W'('h1010);

    logic [7:0] meas_time;

    // Map the reference-clock code to a measurement time.
    always_comb begin
        case (3'(ref_sel))
            REF_50M:           meas_time = 8'h20;
            REF_19M2, REF_20M: meas_time = 8'h04;
            default:           meas_time = 8'h08;
        endcase
    end

    // Choose the address and data of the current step.
    always_comb begin
        case (step_idx)
            2'd0: begin addr = A_LOS;   data = LOS_WORD;   end
            2'd1: begin addr = A_BOOST; data = BOOST_WORD; end
            2'd2: begin addr = A_RXDET; data = DATA_W'(meas_time) << MEAS_LSB; end
            default: begin addr = '0; data = '0; end
        endcase
    end
endmodule

// File: rtl/phy_cal_fsm.sv
// Module: phy_cal_fsm
// Sequences the three writes. It raises a request, waits for the master's
// answer, leaves one idle cycle between writes, and ends early on an error in
// step 1 or 2.
// Assumes: wr_done and wr_err are single-cycle strobes and are never high
// together; if they are, the error wins.
module phy_cal_fsm
    import phy_cal_pkg::*;
#(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] ref_sel_in,
    input  logic             wr_done,
    input  logic             wr_err,
    output logic             req,
    output logic             busy,
    output logic             fin,
    output logic             accept,
    output logic             fail_set,
    output logic [1:0]       fail_step,
    output logic [1:0]       step_idx,
    output logic [SEL_W-1:0] ref_sel_q
);
    localparam logic [1:0] LAST_IDX = 2'(NUM_STEPS - 1);

    seq_state_t state_q, state_d;
    logic [1:0] idx_q, idx_d;
    logic       resp;

    assign resp      = (state_q == ST_REQ) && (wr_done || wr_err);
    assign accept    = (state_q == ST_IDLE) && start;
    assign fail_set  = (state_q == ST_REQ) && wr_err;
    assign fail_step = 2'(idx_q + 2'd1);
    assign req       = (state_q == ST_REQ);
    assign busy      = (state_q != ST_IDLE);
    assign fin       = (state_q == ST_FIN);
    assign step_idx  = idx_q;

    // Work out the next state and step index.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        case (state_q)
            ST_IDLE: if (start) begin state_d = ST_REQ; idx_d = 2'd0; end
            ST_REQ: if (resp) begin
                if (idx_q == LAST_IDX || wr_err) state_d = ST_FIN;
                else begin state_d = ST_GAP; idx_d = 2'(idx_q + 2'd1); end
            end
            ST_GAP:  state_d = ST_REQ;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State registers; the select code is captured when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= 2'd0;
            ref_sel_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (accept) ref_sel_q <= ref_sel_in;
        end
    end

    // R5: the step index never goes past the last write
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);
    // R6: an error in an early step goes straight to completion
    p_abort_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr_err && idx_q < LAST_IDX) |=> (fin && !req));
    // R7: the last step's answer, good or bad, leads to completion
    p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (wr_done || wr_err) && idx_q == LAST_IDX) |=> fin);
    // R9: a start while busy changes neither the state nor the step
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin && start && !(wr_done || wr_err)) |=> busy && $stable(idx_q));
endmodule

// File: rtl/phy_cal_status.sv
// Module: phy_cal_status
// Holds the error flag and the failing-step number. They are cleared when a
// start is accepted and set by a failed write.
// Assumes: clear and set never happen in the same cycle.
module phy_cal_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set,
    input  logic [1:0] set_step,
    output logic       err,
    output logic [1:0] step
);
    // Status register: cleared on start, loaded on a failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err  <= 1'b0;
            step <= 2'd0;
        end else if (clr) begin
            err  <= 1'b0;
            step <= 2'd0;
        end else if (set) begin
            err  <= 1'b1;
            step <= set_step;
        end
    end

    // R8: the step number is non-zero exactly when the error flag is set
    p_step_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err == (step != 2'd0));
endmodule

// File: rtl/phy_cal_seq.sv
// Module: phy_cal_seq (top)
// PHY calibration write sequencer: three ordered tuning writes through a
// request/done/error master port, with completion and failure reporting.
// Assumes: the master answers each request with one done or error strobe.
module phy_cal_seq #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  ref_sel_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_done_i,
    input  logic              wr_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        fail_step_o
);
    logic             accept, fail_set;
    logic [1:0]       fail_step, step_idx;
    logic [SEL_W-1:0] ref_sel_q;
    logic [ADDR_W-1:0] addr_raw;
    logic [DATA_W-1:0] data_raw;

    phy_cal_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start_i), .ref_sel_in(ref_sel_i),
        .wr_done(wr_done_i), .wr_err(wr_err_i), .req(wr_req_o),
        .busy(busy_o), .fin(done_o), .accept(accept), .fail_set(fail_set),
        .fail_step(fail_step), .step_idx(step_idx), .ref_sel_q(ref_sel_q)
    );

    phy_cal_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_tab (
        .step_idx(step_idx), .ref_sel(ref_sel_q), .addr(addr_raw), .data(data_raw)
    );

    phy_cal_status u_stat (
        .clk(clk), .rst_n(rst_n), .clr(accept), .set(fail_set),
        .set_step(fail_step), .err(err_o), .step(fail_step_o)
    );

    // Address and data are driven only while a request is pending.
    assign wr_addr_o = wr_req_o ? addr_raw : '0;
    assign wr_data_o = wr_req_o ? data_raw : '0;

    // R5: address and data hold steady while a request waits for its answer
    p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_done_i && !wr_err_i) |=>
            (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));
    // R8: outside a sequence and without a start, the status holds
    p_status_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(err_o) && $stable(fail_step_o)));
    // R8: the done pulse lasts exactly one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/sim_phy_cal_seq.sv
// Bench for phy_cal_seq. A behavioural reference model is compared on every
// clock, and per-run checks look at the writes that were collected.
module sim_phy_cal_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  ref_sel_i = 3'd0;
    logic        wr_done_i = 1'b0, wr_err_i = 1'b0;
    logic        wr_req_o, busy_o, done_o, err_o;
    logic [15:0] wr_addr_o, wr_data_o;
    logic [1:0]  fail_step_o;

    int checks = 0, errors = 0, cycles = 0;

    phy_cal_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_sel_i(ref_sel_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_done_i(wr_done_i), .wr_err_i(wr_err_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .fail_step_o(fail_step_o)
    );

    always #5 clk = ~clk;

    // Reference model state
    int m_phase = 0;   // 0 idle, 1 requesting, 2 gap, 3 finishing
    int m_wr = 0;      // writes answered so far in this run
    int m_sel = 0;
    bit m_err = 0;
    int m_step = 0;

    // Master responder controls
    int fail_at = 0, latency = 0, wait_cnt = 0;
    int got_n = 0;
    logic [15:0] got_addr[$];
    logic [15:0] got_data[$];

    function automatic logic [15:0] exp_addr(int k);
        case (k) 0: return 16'h0015; 1: return 16'h0012; default: return 16'h1010; endcase
    endfunction

    function automatic logic [15:0] exp_data(int k, int sel);
        if (k == 0) return 16'hA409;
        if (k == 1) return 16'hA000;
        if (sel == 3) return 16'h0200;
        if (sel == 0 || sel == 1) return 16'h0040;
        return 16'h0080;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model update on the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_wr = 0; m_err = 0; m_step = 0; m_sel = 0;
        end else begin
            case (m_phase)
                0: if (start_i) begin
                    m_phase = 1; m_wr = 0; m_sel = int'(ref_sel_i); m_err = 0; m_step = 0;
                end
                1: if (wr_done_i || wr_err_i) begin
                    if (wr_err_i) begin m_err = 1; m_step = m_wr + 1; end
                    m_wr++;
                    m_phase = (m_wr == 3 || wr_err_i) ? 3 : 2;
                end
                2: m_phase = 1;
                default: m_phase = 0;
            endcase
        end
    end

    // Compare every cycle at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(wr_req_o == (m_phase == 1), "R5", "wr_req_o", wr_req_o, m_phase == 1);
            check(busy_o == (m_phase != 0), "R9", "busy_o", busy_o, m_phase != 0);
            check(done_o == (m_phase == 3), "R8", "done_o", done_o, m_phase == 3);
            check(err_o == m_err, "R8", "err_o", err_o, m_err);
            check(int'(fail_step_o) == m_step, "R8", "fail_step_o", fail_step_o, m_step);
            if (m_phase == 1) begin
                check(wr_addr_o == exp_addr(m_wr), "R5", "wr_addr_o", wr_addr_o, exp_addr(m_wr));
                check(wr_data_o == exp_data(m_wr, m_sel), "R3", "wr_data_o", wr_data_o,
                      exp_data(m_wr, m_sel));
            end
        end
    end

    // Master responder: answers a pending request after 'latency' cycles
    always @(negedge clk) begin
        wr_done_i <= 1'b0;
        wr_err_i  <= 1'b0;
        if (rst_n && wr_req_o && !(wr_done_i || wr_err_i)) begin
            if (wait_cnt >= latency) begin
                got_addr.push_back(wr_addr_o);
                got_data.push_back(wr_data_o);
                got_n++;
                if (got_n == fail_at) wr_err_i <= 1'b1; else wr_done_i <= 1'b1;
                wait_cnt = 0;
            end else wait_cnt++;
        end
    end

    // Watchdog
    always @(negedge clk) if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_seq(int sel, int fail_step, int lat, int extra_start_at);
        int n;
        got_addr.delete(); got_data.delete(); got_n = 0;
        fail_at = fail_step; latency = lat; wait_cnt = 0;
        @(negedge clk);
        ref_sel_i = 3'(sel);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ref_sel_i = 3'(~sel);  // later changes must not matter (R4)
        n = 1;
        while (!done_o) begin
            if (n == extra_start_at) start_i = 1'b1; else start_i = 1'b0;
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        begin
            int exp_n = (fail_step == 1 || fail_step == 2) ? fail_step : 3;
            check(got_n == exp_n, "R6", "write count", got_n, exp_n);
            for (int k = 0; k < got_n && k < 3; k++) begin
                check(got_addr[k] == exp_addr(k), k == 0 ? "R1" : (k == 1 ? "R2" : "R3"),
                      "addr", got_addr[k], exp_addr(k));
                check(got_data[k] == exp_data(k, sel), sel > 3 ? "R4" : "R3",
                      "data", got_data[k], exp_data(k, sel));
            end
            check(err_o == (fail_step != 0), "R7", "err_o at done", err_o, fail_step != 0);
            check(int'(fail_step_o) == fail_step, "R7", "fail_step_o at done",
                  fail_step_o, fail_step);
        end
        // Status held after completion, with stray responses ignored (R9)
        @(negedge clk);
        wr_done_i <= 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!busy_o, "R9", "busy after stray response", busy_o, 0);
        check(int'(fail_step_o) == fail_step, "R8", "fail_step held", fail_step_o, fail_step);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!wr_req_o && !busy_o && !done_o && !err_o && fail_step_o == 0,
              "R10", "outputs in reset", {wr_req_o, busy_o, done_o, err_o, fail_step_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !err_o, "R10", "outputs after reset", {busy_o, err_o}, 0);
        for (int s = 0; s < 8; s++) run_seq(s, 0, s % 3, 0);  // R3, R4
        run_seq(2, 1, 1, 0);   // R6, first step fails
        run_seq(3, 2, 0, 0);   // R6, second step fails
        run_seq(0, 3, 2, 0);   // R7, last step fails
        run_seq(1, 0, 0, 0);   // R8, status cleared by new start
        run_seq(3, 0, 2, 3);   // R9, start while busy
        run_seq(5, 0, 0, 2);   // R9, start while busy
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule